// File: doc/BRIEF.md
# Memory Self-Test Job Scheduler

This block sits ahead of a memory built-in self-test engine. It decides which test jobs that engine runs. Software writes four control words through a small write port: two words that select RAM groups (64 groups in all), one word that selects test algorithms (32 in all), and an override control word. A start pulse copies these settings into a working set. The scheduler then steps through every enabled algorithm and, for each one, through every selected RAM group.

A (algorithm, group) pair becomes a job only when the algorithm can handle that group's memory type. Both lookup tables are constant parameters: one gives the type of each group, the other gives the types each algorithm supports. Each job goes to the engine over a valid/ready handshake that carries the 1-based algorithm number and group number. The scheduler then waits for the engine's done pulse before it looks for the next pair. A busy flag covers the whole run. A one-cycle finished pulse closes it. The number of jobs handed over during the run is available on an output.

Top module: `mbist_job_sched`

## Requirements
- R1: After reset, both group-select words read all ones, the algorithm word reads zero, the override word reads 3'b001, and `busy`, `finished`, `job_valid` and `job_count` are zero.
- R2: While idle, a write with `wr_sel`=0 loads the group word for groups 1–32, `wr_sel`=1 loads the word for groups 33–64, `wr_sel`=2 loads the algorithm word and `wr_sel`=3 loads override bit 0. Bit n-1 of the group mask stands for group n, and bit n-1 of the algorithm word stands for algorithm n. Override bits 2:1 always read zero, whatever is written to them.
- R3: Writes made while `busy` is high leave all three registers unchanged.
- R4: When the latched override bit 0 is 1, every group counts as selected and the group mask has no effect. When it is 0, only groups whose mask bit is set are used.
- R5: A pair is issued only if the algorithm supports the group's type. The default group types are ROM for groups 1–2, two-port for groups 4–8 and 14, and single-port for all others. The default support is: algorithm 1 on ROM, algorithm 2 on single-port and two-port, algorithms 3, 5, 7, 9, 11 and 13 on single-port, algorithm 4 on two-port, and no other algorithm on any type.
- R6: Jobs are issued in ascending algorithm order, and within each algorithm in ascending group order. `job_alg` and `job_grp` carry the 1-based numbers.
- R7: `job_valid` holds with stable `job_alg`/`job_grp` until `job_ready` is sampled high. It is low in the following cycle, and no new job appears until `job_done` has been pulsed.
- R8: If no enabled pair is compatible, no job is issued. The finished pulse arrives N_ALG cycles after `busy` rises.
- R9: `busy` rises in the cycle after `start` is sampled. `finished` is a one-cycle pulse in the cycle `busy` falls. A `start` while busy is ignored.
- R10: `job_count` clears at start and counts accepted handshakes of the current run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 group low, 1 group high, 2 algorithm, 3 override |
| wr_data | input | DW | Write data |
| start | input | 1 | Starts a run when idle |
| grp_mask | output | 2*DW | Group-select registers, high word on top |
| alg_mask | output | DW | Algorithm-select register |
| ovr_ctl | output | 3 | Override register; bits 2:1 are reserved and read zero |
| busy | output | 1 | High during a run |
| finished | output | 1 | One-cycle end-of-run pulse |
| job_count | output | CW | Jobs accepted in the current or last run |
| job_valid | output | 1 | Job offered to the engine |
| job_ready | input | 1 | Engine accepts the job |
| job_alg | output | AW | 1-based algorithm number |
| job_grp | output | GW | 1-based group number |
| job_done | input | 1 | Engine completed the job |

## Verification
A register write shows on the register outputs at the first negative edge after the write is sampled. `busy` is high at the first negative edge after `start` is sampled. The earliest job becomes valid one cycle later. `job_valid` is low at the first negative edge after the handshake edge. When no pair qualifies, `finished` appears exactly 32 negative edges after `busy` is first seen. The bench drives every input and samples every output on the falling edge, so each check lands one half cycle after the register that produces the value. It also drives `job_ready` and `job_done` late, and checks that the job stays stable and that no new job appears in the meantime.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int TYPE_W  = 2;
  localparam int N_TYPE  = 4;
  localparam int TY_SP   = 0;
  localparam int TY_TP   = 1;
  localparam int TY_ROM  = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } sched_st_e;

  // Memory type of each of 64 groups, TYPE_W bits per group.
  function automatic logic [127:0] dflt_grp_types();
    logic [127:0] r;
    int n;
    r = '0;
    for (int g = 0; g < 64; g++) begin
      n = g + 1;
      if ((n >= 4 && n <= 8) || n == 14)
        r[2*g +: 2] = 2'(TY_TP);
      else if (n <= 2)
        r[2*g +: 2] = 2'(TY_ROM);
      else
        r[2*g +: 2] = 2'(TY_SP);
    end
    return r;
  endfunction

  // Supported-type bitmask of each of 32 algorithms, N_TYPE bits each.
  function automatic logic [127:0] dflt_alg_support();
    logic [127:0] r;
    int n;
    r = '0;
    for (int a = 0; a < 32; a++) begin
      n = a + 1;
      if (n == 1) r[4*a + TY_ROM] = 1'b1;
      if (n == 2) begin
        r[4*a + TY_SP] = 1'b1;
        r[4*a + TY_TP] = 1'b1;
      end
      if (n == 4) r[4*a + TY_TP] = 1'b1;
      if ((n % 2) == 1 && n >= 3 && n <= 13) r[4*a + TY_SP] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/mbist_sel_regs.sv
module mbist_sel_regs #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lock,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  output logic [2*DW-1:0] grp_q,
  output logic [DW-1:0]   alg_q,
  output logic [2:0]      ovr_q
);
  logic wr_ok;
  assign wr_ok = wr_en && !lock;

  for (genvar w = 0; w < 2; w++) begin : g_grp_word
    always_ff @(posedge clk) begin
      if (rst)
        grp_q[w*DW +: DW] <= '1;
      else if (wr_ok && wr_sel == 2'(w))
        grp_q[w*DW +: DW] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alg_q <= '0;
      ovr_q <= 3'b001;
    end else if (wr_ok) begin
      if (wr_sel == 2'd2) alg_q <= wr_data;
      if (wr_sel == 2'd3) ovr_q <= {2'b00, wr_data[0]};
    end
  end
endmodule

// File: rtl/mbist_compat.sv
module mbist_compat #(
  parameter int N_GRP  = 64,
  parameter int TYPE_W = 2,
  parameter int N_TYPE = 4,
  parameter logic [N_GRP*TYPE_W-1:0] GRP_TYPE = '0
) (
  input  logic [N_TYPE-1:0] sup_row,
  output logic [N_GRP-1:0]  ok_vec
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam logic [TYPE_W-1:0] TY = GRP_TYPE[g*TYPE_W +: TYPE_W];
    assign ok_vec[g] = sup_row[TY];
  end
endmodule

// File: rtl/mbist_pick_first.sv
module mbist_pick_first #(
  parameter int W  = 64,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mbist_job_sched.sv
module mbist_job_sched #(
  parameter int DW = 32,
  parameter logic [2*DW*mbist_pkg::TYPE_W-1:0] GRP_TYPE = mbist_pkg::dflt_grp_types(),
  parameter logic [DW*mbist_pkg::N_TYPE-1:0]   ALG_SUP  = mbist_pkg::dflt_alg_support(),
  localparam int N_GRP = 2 * DW,
  localparam int N_ALG = DW,
  localparam int AW    = $clog2(N_ALG + 1),
  localparam int GW    = $clog2(N_GRP + 1),
  localparam int CW    = $clog2(N_ALG * N_GRP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             start,
  output logic [N_GRP-1:0] grp_mask,
  output logic [DW-1:0]    alg_mask,
  output logic [2:0]       ovr_ctl,
  output logic             busy,
  output logic             finished,
  output logic [CW-1:0]    job_count,
  output logic             job_valid,
  input  logic             job_ready,
  output logic [AW-1:0]    job_alg,
  output logic [GW-1:0]    job_grp,
  input  logic             job_done
);
  import mbist_pkg::*;

  localparam int AI = $clog2(N_ALG);
  localparam int GI = $clog2(N_GRP);

  sched_st_e        st;
  logic [N_GRP-1:0] grp_l;
  logic [N_ALG-1:0] alg_l;
  logic             ovr_l;
  logic [AI-1:0]    alg_idx;
  logic [GW-1:0]    grp_from;
  logic [GI-1:0]    cur_grp;

  logic [N_TYPE-1:0] sup_row;
  logic [N_GRP-1:0]  ok_vec;
  logic [N_GRP-1:0]  from_vec;
  logic [N_GRP-1:0]  cand;
  logic              pick_hit;
  logic [GI-1:0]     pick_idx;

  mbist_sel_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .lock    (busy),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .grp_q   (grp_mask),
    .alg_q   (alg_mask),
    .ovr_q   (ovr_ctl)
  );

  assign sup_row = ALG_SUP[alg_idx*N_TYPE +: N_TYPE];

  mbist_compat #(
    .N_GRP    (N_GRP),
    .TYPE_W   (TYPE_W),
    .N_TYPE   (N_TYPE),
    .GRP_TYPE (GRP_TYPE)
  ) u_compat (
    .sup_row (sup_row),
    .ok_vec  (ok_vec)
  );

  always_comb begin
    for (int g = 0; g < N_GRP; g++)
      from_vec[g] = (g >= int'(grp_from));
  end

  assign cand = ok_vec & from_vec & (ovr_l ? {N_GRP{1'b1}} : grp_l)
              & {N_GRP{alg_l[alg_idx]}};

  mbist_pick_first #(.W(N_GRP)) u_pick (
    .vec (cand),
    .hit (pick_hit),
    .idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      busy      <= 1'b0;
      finished  <= 1'b0;
      job_valid <= 1'b0;
      job_alg   <= '0;
      job_grp   <= '0;
      job_count <= '0;
      grp_l     <= '0;
      alg_l     <= '0;
      ovr_l     <= 1'b0;
      alg_idx   <= '0;
      grp_from  <= '0;
      cur_grp   <= '0;
    end else begin
      finished <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            grp_l     <= grp_mask;
            alg_l     <= alg_mask;
            ovr_l     <= ovr_ctl[0];
            alg_idx   <= '0;
            grp_from  <= '0;
            job_count <= '0;
            busy      <= 1'b1;
            st        <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (pick_hit) begin
            job_valid <= 1'b1;
            job_alg   <= AW'(alg_idx) + AW'(1);
            job_grp   <= GW'(pick_idx) + GW'(1);
            cur_grp   <= pick_idx;
            st        <= ST_ISSUE;
          end else if (alg_idx == AI'(N_ALG - 1)) begin
            busy     <= 1'b0;
            finished <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            alg_idx  <= alg_idx + AI'(1);
            grp_from <= '0;
          end
        end
        ST_ISSUE: begin
          if (job_ready) begin
            job_valid <= 1'b0;
            job_count <= job_count + CW'(1);
            st        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (job_done) begin
            grp_from <= GW'(cur_grp) + GW'(1);
            st       <= ST_SCAN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbist_sched_chk.sv
module mbist_sched_chk #(
  parameter int DW = 32,
  localparam int N_GRP = 2 * DW,
  localparam int AW = $clog2(DW + 1),
  localparam int GW = $clog2(N_GRP + 1),
  localparam int CW = $clog2(DW * N_GRP + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [N_GRP-1:0] grp_mask,
  input logic [DW-1:0]    alg_mask,
  input logic [2:0]       ovr_ctl,
  input logic             busy,
  input logic             finished,
  input logic [CW-1:0]    job_count,
  input logic             job_valid,
  input logic             job_ready,
  input logic [AW-1:0]    job_alg,
  input logic [GW-1:0]    job_grp
);
  // R2: reserved override bits never leave zero
  a_r2_rsv_zero: assert property (@(posedge clk) disable iff (rst)
    ovr_ctl[2:1] == 2'b00);

  // R3: registers frozen across an edge where busy was already high
  a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> ($stable(grp_mask) && $stable(alg_mask) && $stable(ovr_ctl)));

  // R7: offered job holds until accepted
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (job_valid && !job_ready) |=> (job_valid && $stable(job_alg) && $stable(job_grp)));

  // R7: valid drops after the handshake
  a_r7_drop: assert property (@(posedge clk) disable iff (rst)
    (job_valid && job_ready) |=> !job_valid);

  // R9: finished lasts one cycle
  a_r9_fin_pulse: assert property (@(posedge clk) disable iff (rst)
    finished |=> !finished);

  // R9: finished coincides with busy falling
  a_r9_fin_busy: assert property (@(posedge clk) disable iff (rst)
    finished |-> (!busy && $past(busy)));

  // R10: each handshake adds one to the count
  a_r10_count: assert property (@(posedge clk) disable iff (rst)
    (job_valid && job_ready) |=> (job_count == $past(job_count) + CW'(1)));

  // R7: jobs only offered during a run
  a_r7_valid_busy: assert property (@(posedge clk) disable iff (rst)
    job_valid |-> busy);
endmodule

bind mbist_job_sched mbist_sched_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .grp_mask  (grp_mask),
  .alg_mask  (alg_mask),
  .ovr_ctl   (ovr_ctl),
  .busy      (busy),
  .finished  (finished),
  .job_count (job_count),
  .job_valid (job_valid),
  .job_ready (job_ready),
  .job_alg   (job_alg),
  .job_grp   (job_grp)
);

// File: tb/sim_mbist_job_sched.sv
`timescale 1ns/1ps
module sim_mbist_job_sched;
  localparam int DW = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        start = 1'b0;
  logic [63:0] grp_mask;
  logic [31:0] alg_mask;
  logic [2:0]  ovr_ctl;
  logic        busy, finished, job_valid;
  logic        job_ready = 1'b0;
  logic        job_done = 1'b0;
  logic [11:0] job_count;
  logic [5:0]  job_alg;
  logic [6:0]  job_grp;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  mbist_job_sched #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .grp_mask(grp_mask), .alg_mask(alg_mask), .ovr_ctl(ovr_ctl),
    .busy(busy), .finished(finished), .job_count(job_count),
    .job_valid(job_valid), .job_ready(job_ready), .job_alg(job_alg),
    .job_grp(job_grp), .job_done(job_done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Start a run, act as the engine, compare each job with the expected list.
  task automatic run_expect(input string req, input int n_exp, input int ea[8],
                            input int eg[8], input int rdy_wait, input int done_wait,
                            input int exp_lat, input bit poke);
    int got = 0;
    int lat = 0;
    bit poked = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", 64'(busy), 64'd1, "busy one cycle after start");
    chk("R10", 64'(job_count), 64'd0, "count cleared at start");
    while (!finished && lat < 5000) begin
      if (job_valid) begin
        if (got < n_exp) begin
          chk(req, 64'(job_alg), 64'(ea[got]), "job algorithm");
          chk(req, 64'(job_grp), 64'(eg[got]), "job group");
        end else begin
          chk(req, 64'(got), 64'(n_exp), "extra job issued");
        end
        if (poke && !poked) begin
          poked = 1;
          start = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h0;
          @(negedge clk);
          start = 1'b0; wr_sel = 2'd2; wr_data = 32'hFFFF;
          @(negedge clk);
          wr_en = 1'b0;
        end
        for (int k = 0; k < rdy_wait; k++) begin
          @(negedge clk);
          chk("R7", {63'd0, job_valid}, 64'd1, "valid held before ready");
          chk("R7", 64'(job_grp), 64'(got < n_exp ? eg[got] : 0), "group stable");
        end
        job_ready = 1'b1;
        @(negedge clk);
        job_ready = 1'b0;
        chk("R7", 64'(job_valid), 64'd0, "valid low after handshake");
        for (int k = 0; k < done_wait; k++) begin
          @(negedge clk);
          chk("R7", 64'(job_valid), 64'd0, "no new job before done");
        end
        job_done = 1'b1;
        @(negedge clk);
        job_done = 1'b0;
        got++;
        lat = 0;
      end else begin
        @(negedge clk);
        lat++;
      end
    end
    chk(req, 64'(finished), 64'd1, "run finished");
    chk("R9", 64'(busy), 64'd0, "busy low with finished");
    if (exp_lat >= 0) chk("R8", 64'(lat), 64'(exp_lat), "finish latency");
    chk(req, 64'(got), 64'(n_exp), "number of jobs");
    chk("R10", 64'(job_count), 64'(n_exp), "job count");
    @(negedge clk);
    chk("R9", 64'(finished), 64'd0, "finished is one cycle");
  endtask

  task automatic t_reset();
    chk("R1", grp_mask, 64'hFFFF_FFFF_FFFF_FFFF, "group reset");
    chk("R1", 64'(alg_mask), 64'd0, "alg reset");
    chk("R1", 64'(ovr_ctl), 64'd1, "override reset");
    chk("R1", {61'd0, busy, finished, job_valid}, 64'd0, "flags reset");
    chk("R1", 64'(job_count), 64'd0, "count reset");
  endtask

  task automatic t_regs();
    wr(2'd3, 32'h7);
    chk("R2", 64'(ovr_ctl), 64'd1, "reserved bits stay zero");
    wr(2'd3, 32'h0);
    chk("R2", 64'(ovr_ctl), 64'd0, "override cleared");
    wr(2'd0, 32'h0000_0004);
    wr(2'd1, 32'hA5A5_0001);
    wr(2'd2, 32'h0000_0014);
    chk("R2", grp_mask, 64'hA5A5_0001_0000_0004, "group words");
    chk("R2", 64'(alg_mask), 64'h14, "alg word");
  endtask

  task automatic t_pair_filter();
    wr(2'd1, 32'h0);
    // group 3 single-port; algorithms 3 and 5
    run_expect("R5", 2, '{3,5,0,0,0,0,0,0}, '{3,3,0,0,0,0,0,0}, 0, 0, -1, 0);
  endtask

  task automatic t_none();
    wr(2'd2, 32'h0000_0008);
    run_expect("R8", 0, '{0,0,0,0,0,0,0,0}, '{0,0,0,0,0,0,0,0}, 0, 0, 32, 0);
  endtask

  task automatic t_override();
    wr(2'd3, 32'h1);
    run_expect("R4", 6, '{4,4,4,4,4,4,0,0}, '{4,5,6,7,8,14,0,0}, 3, 2, -1, 0);
    wr(2'd3, 32'h0);
  endtask

  task automatic t_order();
    wr(2'd0, 32'h0000_0005);
    wr(2'd1, 32'h0000_0001);
    wr(2'd2, 32'h0000_0005);
    run_expect("R6", 3, '{1,3,3,0,0,0,0,0}, '{1,3,33,0,0,0,0,0}, 1, 1, -1, 0);
    wr(2'd0, 32'h0000_000D);
    wr(2'd1, 32'h8000_0000);
    wr(2'd2, 32'h8000_0002);
    run_expect("R6", 3, '{2,2,2,0,0,0,0,0}, '{3,4,64,0,0,0,0,0}, 0, 3, -1, 0);
  endtask

  task automatic t_busy_lock();
    wr(2'd0, 32'h0000_0004);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0000_0014);
    run_expect("R3", 2, '{3,5,0,0,0,0,0,0}, '{3,3,0,0,0,0,0,0}, 2, 0, -1, 1);
    chk("R3", grp_mask, 64'h4, "group unchanged by busy write");
    chk("R3", 64'(alg_mask), 64'h14, "alg unchanged by busy write");
    chk("R9", 64'(busy), 64'd0, "start while busy did not restart");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_pair_filter();
    t_none();
    t_override();
    t_order();
    t_busy_lock();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule